// File: doc/BRIEF.md
# Two-Group Memory Request Scheduler

This block chooses which pending DRAM request in a shared queue is issued next. Each queue entry holds a request from one of several cores or applications. It is tagged with a source number, a target bank, a target row and an age. The block compares each entry's row against the row currently open in that entry's bank to see whether the access would hit the row buffer.

Sources fall into two classes: trusted and penalised. No ranking among individual sources exists. The block remembers which source it granted last and how many grants that source has received in an unbroken run. Once a run grows to a threshold, the block penalises that source by setting its bit in a penalty vector. A free-running timer clears the whole vector at a fixed period, so the classes always reflect recent behaviour.

Arbitration order is as follows:
1. An entry from a trusted source beats an entry from a penalised source.
2. Within a class, a row-buffer hit beats a miss.
3. After that, the greater age wins.
4. Remaining ties go to the lowest entry index.

Top module: `blist_sched`

## Requirements
- R1: The grant is registered. Inputs applied before a rising edge produce `grant_valid`/`grant_idx` after that edge. When no entry is valid, `grant_valid` is 0 and `grant_idx` is 0.
- R2: A valid entry whose source is not penalised always wins over any entry whose source is penalised.
- R3: Within one class, an entry is a hit when its row equals `open_row` of its own bank, and a hit wins over a miss. Entry i uses bits [i*W +: W] of each flat bus. Bank b uses bits [b*ROW_W +: ROW_W] of `open_row`. Source and bank are binary numbers.
- R4: After class and hit status, the entry with the larger age value wins. Equal keys go to the lowest index.
- R5: Granting the same source as the previous grant adds one to the run count, saturating at THRESH. Granting a different source, or the first grant after reset, sets the count to 1 and records the new source.
- R6: The grant that brings the run count to THRESH sets that source's penalty bit, effective for the next arbitration. With THRESH=3, a source keeps winning for exactly three consecutive grants before a trusted rival takes over.
- R7: A cycle with no valid entry grants nothing and leaves the run count and the recorded source unchanged.
- R8: A cycle counter clears all penalty bits once every CLEAR_INTERVAL cycles. A clear takes priority over a set in the same cycle.
- R9: Reset (synchronous, active high) clears the penalty vector, run count, recorded source, cycle counter and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_ENTRIES | Per-entry valid |
| req_src | input | N_ENTRIES*SRC_W | Per-entry source number |
| req_bank | input | N_ENTRIES*BANK_W | Per-entry bank |
| req_row | input | N_ENTRIES*ROW_W | Per-entry row |
| req_age | input | N_ENTRIES*AGE_W | Per-entry age, larger is older |
| open_row | input | N_BANKS*ROW_W | Currently open row of each bank |
| grant_idx | output | IDX_W | Registered winning entry index |
| grant_valid | output | 1 | Registered grant strobe |

## Verification
The bench builds the block with four entries, four sources and four banks, THRESH=3 and CLEAR_INTERVAL=64. The low threshold lets a run reach the penalty point within a handful of grants. It also lets a second source get penalised in turn, which exposes the all-penalised fallback to age order. The short interval brings a periodic clear within a 70-cycle idle gap, and it also shows that a source whose run continues past the clear is penalised again at once.

// File: rtl/blist_pkg.sv
package blist_pkg;
  function automatic int wid(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/blist_arbiter.sv
module blist_arbiter import blist_pkg::*; #(
  parameter int N_ENTRIES = 8,
  parameter int N_SRC     = 4,
  parameter int N_BANKS   = 8,
  parameter int ROW_W     = 14,
  parameter int AGE_W     = 8,
  localparam int SRC_W    = wid(N_SRC),
  localparam int BANK_W   = wid(N_BANKS),
  localparam int IDX_W    = wid(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]        req_valid,
  input  logic [N_ENTRIES*SRC_W-1:0]  req_src,
  input  logic [N_ENTRIES*BANK_W-1:0] req_bank,
  input  logic [N_ENTRIES*ROW_W-1:0]  req_row,
  input  logic [N_ENTRIES*AGE_W-1:0]  req_age,
  input  logic [N_BANKS*ROW_W-1:0]    open_row,
  input  logic [N_SRC-1:0]            penalty,
  output logic                        win_vld,
  output logic [IDX_W-1:0]            win_idx
);
  localparam int KEY_W = AGE_W + 2;

  logic [KEY_W-1:0] key [N_ENTRIES];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_key
    logic [SRC_W-1:0]  src;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  open;
    logic              hit;
    assign src  = req_src[i*SRC_W +: SRC_W];
    assign bank = req_bank[i*BANK_W +: BANK_W];
    assign open = open_row[32'(bank)*ROW_W +: ROW_W];
    assign hit  = (req_row[i*ROW_W +: ROW_W] == open);
    assign key[i] = {~penalty[src], hit, req_age[i*AGE_W +: AGE_W]};
  end

  always_comb begin
    logic [KEY_W-1:0] best;
    best    = '0;
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (req_valid[i] && (!win_vld || key[i] > best)) begin
        best    = key[i];
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/blist_tracker.sv
module blist_tracker import blist_pkg::*; #(
  parameter int N_SRC          = 4,
  parameter int THRESH         = 4,
  parameter int CLEAR_INTERVAL = 10000,
  localparam int SRC_W         = wid(N_SRC),
  localparam int CNT_W         = wid(THRESH + 1),
  localparam int CYC_W         = wid(CLEAR_INTERVAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serve_vld,
  input  logic [SRC_W-1:0] serve_src,
  output logic [N_SRC-1:0] penalty
);
  logic [SRC_W-1:0] last_src;
  logic [CNT_W-1:0] streak, streak_nxt;
  logic [CYC_W-1:0] cyc;
  logic             clear_now;

  assign clear_now = (cyc == CYC_W'(CLEAR_INTERVAL - 1));

  always_comb begin
    if (serve_src == last_src && streak != '0)
      streak_nxt = (streak == CNT_W'(THRESH)) ? streak : streak + 1'b1;
    else
      streak_nxt = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0;
    end else begin
      cyc <= clear_now ? '0 : cyc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_src <= '0;
      streak   <= '0;
    end else if (serve_vld) begin
      last_src <= serve_src;
      streak   <= streak_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      penalty <= '0;
    else if (clear_now)
      penalty <= '0;
    else if (serve_vld && streak_nxt >= CNT_W'(THRESH))
      penalty[serve_src] <= 1'b1;
  end

  p_streak_one_r5: assert property (@(posedge clk) disable iff (rst)
    serve_vld && (serve_src != last_src) |=> streak == CNT_W'(1));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !serve_vld |=> $stable(streak) && $stable(last_src));

  p_set_at_thresh_r6: assert property (@(posedge clk) disable iff (rst)
    serve_vld && serve_src == last_src && streak == CNT_W'(THRESH - 1) &&
    streak != '0 && !clear_now |=> penalty[$past(serve_src)]);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cyc == CYC_W'(CLEAR_INTERVAL - 1) |=> penalty == '0);

  p_streak_cap_r5: assert property (@(posedge clk) disable iff (rst)
    streak <= CNT_W'(THRESH));
endmodule

// File: rtl/blist_sched.sv
module blist_sched import blist_pkg::*; #(
  parameter int N_ENTRIES      = 8,
  parameter int N_SRC          = 4,
  parameter int N_BANKS        = 8,
  parameter int ROW_W          = 14,
  parameter int AGE_W          = 8,
  parameter int THRESH         = 4,
  parameter int CLEAR_INTERVAL = 10000,
  localparam int SRC_W         = wid(N_SRC),
  localparam int BANK_W        = wid(N_BANKS),
  localparam int IDX_W         = wid(N_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_ENTRIES-1:0]        req_valid,
  input  logic [N_ENTRIES*SRC_W-1:0]  req_src,
  input  logic [N_ENTRIES*BANK_W-1:0] req_bank,
  input  logic [N_ENTRIES*ROW_W-1:0]  req_row,
  input  logic [N_ENTRIES*AGE_W-1:0]  req_age,
  input  logic [N_BANKS*ROW_W-1:0]    open_row,
  output logic [IDX_W-1:0]            grant_idx,
  output logic                        grant_valid
);
  logic [N_SRC-1:0] penalty;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [SRC_W-1:0] win_src;

  blist_arbiter #(
    .N_ENTRIES(N_ENTRIES), .N_SRC(N_SRC), .N_BANKS(N_BANKS),
    .ROW_W(ROW_W), .AGE_W(AGE_W)
  ) u_arb (
    .req_valid(req_valid), .req_src(req_src), .req_bank(req_bank),
    .req_row(req_row), .req_age(req_age), .open_row(open_row),
    .penalty(penalty), .win_vld(win_vld), .win_idx(win_idx)
  );

  assign win_src = req_src[32'(win_idx)*SRC_W +: SRC_W];

  blist_tracker #(
    .N_SRC(N_SRC), .THRESH(THRESH), .CLEAR_INTERVAL(CLEAR_INTERVAL)
  ) u_trk (
    .clk(clk), .rst(rst), .serve_vld(win_vld), .serve_src(win_src),
    .penalty(penalty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
    end else begin
      grant_valid <= win_vld;
      grant_idx   <= win_vld ? win_idx : '0;
    end
  end

  p_grant_is_valid_r1: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> |(($past(req_valid) >> grant_idx) & N_ENTRIES'(1)));

  p_none_no_grant_r1: assert property (@(posedge clk) disable iff (rst)
    !(|req_valid) |=> !grant_valid && grant_idx == '0);
endmodule

// File: tb/tb_blist_sched.sv
module tb_blist_sched;
  localparam int CLK_P = 10;
  localparam int N = 4;
  localparam int NV = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_valid = '0;
  logic [7:0]  req_src = '0;
  logic [7:0]  req_bank = '0;
  logic [31:0] req_row = '0;
  logic [31:0] req_age = '0;
  logic [31:0] open_row = '0;
  logic [1:0]  grant_idx;
  logic        grant_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  blist_sched #(
    .N_ENTRIES(N), .N_SRC(4), .N_BANKS(4), .ROW_W(8), .AGE_W(8),
    .THRESH(3), .CLEAR_INTERVAL(64)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
    .open_row(open_row), .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  localparam logic [3:0]  V_VALID [NV] = '{4'h0, 4'h3, 4'hF, 4'h5, 4'h8, 4'h7};
  localparam logic [7:0]  V_BANK  [NV] = '{8'h00, 8'h04, 8'h00, 8'h32, 8'h00, 8'h00};
  localparam logic [31:0] V_ROW   [NV] = '{32'h0, 32'h0000_5510, 32'h0101_0101,
                                           32'h0033_0011, 32'h0, 32'h0044_4400};
  localparam logic [31:0] V_AGE   [NV] = '{32'h0, 32'h0000_0132, 32'h0907_0903,
                                           32'h0002_0009, 32'h0, 32'h0008_04C8};
  localparam logic [31:0] V_OPEN  [NV] = '{32'h0, 32'h0000_5500, 32'h0,
                                           32'h3322_0011, 32'hFFFF_FFFF, 32'h0000_0044};
  localparam logic        V_EXPV  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [1:0]  V_EXPI  [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd2};

  task automatic chk(input logic ev, input logic [1:0] ei, input string tag);
    checks++;
    if (grant_valid !== ev || grant_idx !== ei) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, grant_valid, grant_idx, ev, ei);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Two competing entries, both misses: entry0 src0 age 10, entry1 src1 age 5.
  task automatic pair(input logic [1:0] v);
    req_valid = {2'b00, v};
    req_src   = 8'hE4;
    req_bank  = 8'h00;
    req_row   = 32'h0;
    req_age   = 32'h0000_050A;
    open_row  = 32'hFFFF_FFFF;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    do_reset();
    chk(1'b0, 2'd0, "R9 reset outputs");

    // Table: R1 none valid, R3 hit over miss, R4 age/tie, R3 own-bank decode
    for (int k = 0; k < NV; k++) begin
      do_reset();
      req_valid = V_VALID[k];
      req_src   = 8'hE4;
      req_bank  = V_BANK[k];
      req_row   = V_ROW[k];
      req_age   = V_AGE[k];
      open_row  = V_OPEN[k];
      step();
      chk(V_EXPV[k], V_EXPI[k], $sformatf("R1/R3/R4 vector %0d", k));
    end

    // R5/R6/R2: src0 wins three in a row, then penalised
    do_reset();
    pair(2'b11);
    step(); chk(1'b1, 2'd0, "R5 run 1");
    step(); chk(1'b1, 2'd0, "R6 run 2 below threshold");
    step(); chk(1'b1, 2'd0, "R6 run 3 reaches threshold");
    step(); chk(1'b1, 2'd1, "R2 trusted beats penalised");
    step(); chk(1'b1, 2'd1, "R2 src1 run 2");
    step(); chk(1'b1, 2'd1, "R6 src1 run 3");
    step(); chk(1'b1, 2'd0, "R4 both penalised age order");

    // R5: a different source resets the run to one
    do_reset();
    pair(2'b11); step(); step();
    pair(2'b10); step(); chk(1'b1, 2'd1, "R5 other source");
    pair(2'b11);
    step(); chk(1'b1, 2'd0, "R5 restart 1");
    step(); chk(1'b1, 2'd0, "R5 restart 2");
    step(); chk(1'b1, 2'd0, "R5 restart 3");
    step(); chk(1'b1, 2'd1, "R5 penalised after fresh run");

    // R7: idle cycle keeps the run
    do_reset();
    pair(2'b11); step(); step();
    pair(2'b00); step(); chk(1'b0, 2'd0, "R7 idle no grant");
    pair(2'b11);
    step(); chk(1'b1, 2'd0, "R7 run continues to 3");
    step(); chk(1'b1, 2'd1, "R7 penalty after idle");

    // R8: periodic clear
    do_reset();
    pair(2'b11); step(); step(); step();
    pair(2'b00);
    for (int c = 0; c < 70; c++) step();
    pair(2'b11);
    step(); chk(1'b1, 2'd0, "R8 penalty cleared");
    step(); chk(1'b1, 2'd1, "R8 re-penalised by ongoing run");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule